// File: doc/BRIEF.md
# E1 Channel-Associated Signalling Multiframe Multiplexer

This block carries the four-bit ABCD signalling codes of the thirty voice channels of an E1 stream through timeslot 16. It works one timeslot-16 byte at a time. A single-cycle `frame_tick` marks the clock in which the byte for the current frame is exchanged. On the transmit side a 16-frame counter picks what goes into each byte. Frame 0 carries the multiframe alignment quartet 0000 and a low quartet of spare and alarm bits. Each of frames 1 to 15 carries the codes of two channels that lie fifteen channel numbers apart. The codes come from a per-channel register array that is written through a simple write port.

On the receive side the block hunts for the 0000 quartet and confirms it one multiframe later before it declares lock. Once locked, it writes the received codes into a second per-channel array, which is read through a combinational read port, and it marks every received multiframe boundary with a one-cycle pulse. In common-channel mode timeslot 16 is treated as a plain 64 kbit/s data channel. The transmit byte is then taken from an input, and the receive side stays out of lock.

Top module: `cas_mf_mux`

## Requirements
- R1: The transmit frame number advances by one (mod 16) on every `frame_tick`. A tick with `tx_mf_align_n` low makes that tick's frame number 0. The first tick after reset is frame 0. `tx_frame_num` shows the frame number of the byte on `tx_ts16`.
- R2: A frame-0 transmit byte is {0000, X, Y, X, X}, with bit 7 the first bit on the line, X fixed at 1 and Y equal to `tx_remote_alarm` at the tick.
- R3: For frame n from 1 to 15 the transmit byte is {code of channel n, code of channel n+15}. The A bit of a code is its bit 3.
- R4: After reset every transmit channel code is 1101 until it is written. A write to channel 0 or 31 changes no code.
- R5: With `ccs_mode` high, `tx_ts16` takes `tx_ccs_byte` at each tick. In the same mode the receiver leaves lock from the next clock and stores no codes.
- R6: `tx_ts16` is FF after reset, takes its new value in the clock after a tick, and holds it between ticks.
- R7: Receive lock is declared at the second consecutive 0000 high quartet found 16 frames after the first.
- R8: While locked, one missing 0000 quartet at the expected frame 0 keeps lock. Two consecutive misses drop it, and the receiver goes back to the hunt.
- R9: Received codes reset to 1111. They are stored only from frames 1 to 15 received while locked: the high quartet goes to channel n and the low quartet to channel n+15.
- R10: `rx_mf_pulse` is high for one clock after each tick at the expected frame 0 at which lock is held after the tick. This includes the tick that declares lock and a single-miss tick.
- R11: `rd_code` returns 0000 for `rd_chan` 0 or 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ccs_mode | input | 1 | Common-channel mode, timeslot 16 carries data |
| frame_tick | input | 1 | One-cycle strobe per frame for the timeslot-16 byte |
| tx_mf_align_n | input | 1 | Low at a tick forces transmit frame 0; held high to free-run |
| tx_remote_alarm | input | 1 | Y bit sent in frame 0 |
| tx_ccs_byte | input | 8 | Transmit data byte in common-channel mode |
| wr_en | input | 1 | Transmit code write strobe |
| wr_chan | input | 5 | Channel written, 1 to 30 |
| wr_code | input | 4 | ABCD code written |
| tx_ts16 | output | 8 | Transmit timeslot-16 byte |
| tx_frame_num | output | 4 | Frame number of `tx_ts16` |
| rx_ts16 | input | 8 | Received timeslot-16 byte, valid at a tick |
| rx_mf_lock | output | 1 | Receive multiframe lock |
| rx_mf_pulse | output | 1 | Received multiframe boundary pulse |
| rd_chan | input | 5 | Channel read from the receive array |
| rd_code | output | 4 | Received ABCD code of `rd_chan` |

## Verification
A wrong transmit frame counter shows on the very next tick: a 0000 quartet appears in the wrong frame, or codes come out paired with the wrong channels. The random code values make a pairing error visible within one multiframe. A wrong receive alignment state shows as lock or pulse appearing or vanishing sixteen ticks early or late. It also shows as codes written into the array while out of lock, which a read-back of all thirty channels exposes right after the multiframe concerned. Misses are injected one and two at a time so that an off-by-one miss count moves the lock drop by a whole multiframe.

// File: rtl/cas_pkg.sv
package cas_pkg;
   localparam int MF_LEN  = 16;
   localparam int FN_W    = $clog2(MF_LEN);
   localparam int CODE_W  = 4;
   localparam int SLOT_W  = 2 * CODE_W;
   localparam int HALF    = MF_LEN - 1;
   localparam int N_CH    = 2 * HALF;
   localparam int CH_W    = $clog2(N_CH + 2);

   typedef logic [CODE_W-1:0] abcd_t;
   typedef logic [FN_W-1:0]   fnum_t;
   typedef logic [SLOT_W-1:0] slot_t;

   typedef enum logic [1:0] {
      RX_HUNT    = 2'd0,
      RX_CONFIRM = 2'd1,
      RX_LOCKED  = 2'd2
   } rx_state_e;

   function automatic logic is_align_quartet(input slot_t b);
      return b[SLOT_W-1:CODE_W] == '0;
   endfunction
endpackage

// File: rtl/cas_tx_codes.sv
module cas_tx_codes
   import cas_pkg::*;
#(
   parameter abcd_t IDLE_CODE = 4'b1101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_chan,
   input  abcd_t             wr_code,
   input  fnum_t             fn,
   output abcd_t             hi_code,
   output abcd_t             lo_code
);
   abcd_t code_q [1:N_CH];

   for (genvar c = 1; c <= N_CH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            code_q[c] <= IDLE_CODE;
         else if (wr_en && (wr_chan == CH_W'(c)))
            code_q[c] <= wr_code;
      end
   end

   always_comb begin
      hi_code = IDLE_CODE;
      lo_code = IDLE_CODE;
      for (int n = 1; n <= HALF; n++) begin
         if (fn == FN_W'(n)) begin
            hi_code = code_q[n];
            lo_code = code_q[n + HALF];
         end
      end
   end
endmodule

// File: rtl/cas_tx_mux.sv
module cas_tx_mux
   import cas_pkg::*;
#(
   parameter logic  X_BIT      = 1'b1,
   parameter slot_t SLOT_RESET = 8'hFF
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   frame_tick,
   input  logic   align_n,
   input  logic   ccs_mode,
   input  logic   remote_alarm,
   input  slot_t  ccs_byte,
   input  abcd_t  hi_code,
   input  abcd_t  lo_code,
   output fnum_t  fn_next,
   output fnum_t  fn_q,
   output slot_t  ts16_q
);
   slot_t frame0_byte;
   slot_t sig_byte;
   slot_t byte_d;

   assign fn_next     = align_n ? fn_q + 1'b1 : '0;
   assign frame0_byte = {{CODE_W{1'b0}}, X_BIT, remote_alarm, X_BIT, X_BIT};
   assign sig_byte    = {hi_code, lo_code};

   always_comb begin
      if (ccs_mode)
         byte_d = ccs_byte;
      else if (fn_next == '0)
         byte_d = frame0_byte;
      else
         byte_d = sig_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fn_q   <= FN_W'(MF_LEN - 1);
         ts16_q <= SLOT_RESET;
      end else if (frame_tick) begin
         fn_q   <= fn_next;
         ts16_q <= byte_d;
      end
   end
endmodule

// File: rtl/cas_rx_align.sv
module cas_rx_align
   import cas_pkg::*;
#(
   parameter int LOCK_HITS   = 2,
   parameter int DROP_MISSES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   frame_tick,
   input  logic   ccs_mode,
   input  slot_t  rx_byte,
   output logic   lock_q,
   output logic   pulse_q,
   output logic   store_en,
   output fnum_t  store_fn
);
   localparam int HIT_W  = $clog2(LOCK_HITS + 1);
   localparam int MISS_W = $clog2(DROP_MISSES + 1);

   rx_state_e         state_q, state_d;
   fnum_t             fn_q, fn_d, nf;
   logic [HIT_W-1:0]  hits_q, hits_d;
   logic [MISS_W-1:0] miss_q, miss_d;
   logic              pulse_d;
   logic              zero_q4;
   int                h_inc, m_inc;

   assign nf      = fn_q + 1'b1;
   assign zero_q4 = is_align_quartet(rx_byte);
   assign h_inc   = int'(hits_q) + 1;
   assign m_inc   = int'(miss_q) + 1;

   always_comb begin
      state_d = state_q;
      fn_d    = nf;
      hits_d  = hits_q;
      miss_d  = miss_q;
      pulse_d = 1'b0;
      unique case (state_q)
         RX_HUNT: begin
            if (zero_q4) begin
               fn_d = '0;
               if (LOCK_HITS == 1) begin
                  state_d = RX_LOCKED;
                  pulse_d = 1'b1;
                  hits_d  = '0;
               end else begin
                  state_d = RX_CONFIRM;
                  hits_d  = HIT_W'(1);
               end
            end
         end
         RX_CONFIRM: begin
            if (nf == '0) begin
               if (!zero_q4) begin
                  state_d = RX_HUNT;
                  hits_d  = '0;
               end else if (h_inc >= LOCK_HITS) begin
                  state_d = RX_LOCKED;
                  hits_d  = '0;
                  miss_d  = '0;
                  pulse_d = 1'b1;
               end else begin
                  hits_d  = HIT_W'(h_inc);
               end
            end
         end
         RX_LOCKED: begin
            if (nf == '0) begin
               if (zero_q4) begin
                  miss_d  = '0;
                  pulse_d = 1'b1;
               end else if (m_inc >= DROP_MISSES) begin
                  state_d = RX_HUNT;
                  miss_d  = '0;
               end else begin
                  miss_d  = MISS_W'(m_inc);
                  pulse_d = 1'b1;
               end
            end
         end
         default: begin
            state_d = RX_HUNT;
            hits_d  = '0;
            miss_d  = '0;
         end
      endcase
   end

   assign store_en = frame_tick && !ccs_mode && (state_q == RX_LOCKED) && (nf != '0);
   assign store_fn = nf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_HUNT;
         fn_q    <= '0;
         hits_q  <= '0;
         miss_q  <= '0;
         pulse_q <= 1'b0;
      end else if (ccs_mode) begin
         state_q <= RX_HUNT;
         hits_q  <= '0;
         miss_q  <= '0;
         pulse_q <= 1'b0;
      end else if (frame_tick) begin
         state_q <= state_d;
         fn_q    <= fn_d;
         hits_q  <= hits_d;
         miss_q  <= miss_d;
         pulse_q <= pulse_d;
      end else begin
         pulse_q <= 1'b0;
      end
   end

   assign lock_q = (state_q == RX_LOCKED);
endmodule

// File: rtl/cas_rx_store.sv
module cas_rx_store
   import cas_pkg::*;
#(
   parameter abcd_t RESET_CODE = 4'b1111
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            store_en,
   input  fnum_t           store_fn,
   input  slot_t           rx_byte,
   input  logic [CH_W-1:0] rd_chan,
   output abcd_t           rd_code
);
   abcd_t code_q [1:N_CH];

   for (genvar c = 1; c <= N_CH; c++) begin : g_ch
      localparam int FSEL = (c <= HALF) ? c : c - HALF;
      abcd_t src;
      if (c <= HALF) begin : g_hi
         assign src = rx_byte[SLOT_W-1:CODE_W];
      end else begin : g_lo
         assign src = rx_byte[CODE_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            code_q[c] <= RESET_CODE;
         else if (store_en && (store_fn == FN_W'(FSEL)))
            code_q[c] <= src;
      end
   end

   always_comb begin
      rd_code = '0;
      for (int n = 1; n <= N_CH; n++) begin
         if (rd_chan == CH_W'(n))
            rd_code = code_q[n];
      end
   end
endmodule

// File: rtl/cas_mf_mux.sv
module cas_mf_mux
   import cas_pkg::*;
#(
   parameter int          LOCK_HITS     = 2,
   parameter int          DROP_MISSES   = 2,
   parameter logic [3:0]  TX_IDLE_CODE  = 4'b1101,
   parameter logic [3:0]  RX_RESET_CODE = 4'b1111,
   parameter logic        X_BIT         = 1'b1,
   parameter logic [7:0]  SLOT_RESET    = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ccs_mode,
   input  logic       frame_tick,
   input  logic       tx_mf_align_n,
   input  logic       tx_remote_alarm,
   input  logic [7:0] tx_ccs_byte,
   input  logic       wr_en,
   input  logic [4:0] wr_chan,
   input  logic [3:0] wr_code,
   output logic [7:0] tx_ts16,
   output logic [3:0] tx_frame_num,
   input  logic [7:0] rx_ts16,
   output logic       rx_mf_lock,
   output logic       rx_mf_pulse,
   input  logic [4:0] rd_chan,
   output logic [3:0] rd_code
);
   if (LOCK_HITS < 1) begin : g_bad_hits
      $error("LOCK_HITS must be at least 1");
   end
   if (DROP_MISSES < 1) begin : g_bad_miss
      $error("DROP_MISSES must be at least 1");
   end
   if (TX_IDLE_CODE == 4'b0000) begin : g_bad_idle
      $error("TX_IDLE_CODE must not mimic the alignment quartet");
   end
   if (SLOT_W != 8 || CH_W != 5 || FN_W != 4) begin : g_bad_fmt
      $error("package format constants do not match the port widths");
   end

   fnum_t tx_fn_next;
   abcd_t tx_hi, tx_lo;
   logic  st_en;
   fnum_t st_fn;

   cas_tx_codes #(
      .IDLE_CODE (TX_IDLE_CODE)
   ) i_tx_codes (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_chan (wr_chan),
      .wr_code (wr_code),
      .fn      (tx_fn_next),
      .hi_code (tx_hi),
      .lo_code (tx_lo)
   );

   cas_tx_mux #(
      .X_BIT      (X_BIT),
      .SLOT_RESET (SLOT_RESET)
   ) i_tx_mux (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_tick   (frame_tick),
      .align_n      (tx_mf_align_n),
      .ccs_mode     (ccs_mode),
      .remote_alarm (tx_remote_alarm),
      .ccs_byte     (tx_ccs_byte),
      .hi_code      (tx_hi),
      .lo_code      (tx_lo),
      .fn_next      (tx_fn_next),
      .fn_q         (tx_frame_num),
      .ts16_q       (tx_ts16)
   );

   cas_rx_align #(
      .LOCK_HITS   (LOCK_HITS),
      .DROP_MISSES (DROP_MISSES)
   ) i_rx_align (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_tick (frame_tick),
      .ccs_mode   (ccs_mode),
      .rx_byte    (rx_ts16),
      .lock_q     (rx_mf_lock),
      .pulse_q    (rx_mf_pulse),
      .store_en   (st_en),
      .store_fn   (st_fn)
   );

   cas_rx_store #(
      .RESET_CODE (RX_RESET_CODE)
   ) i_rx_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .store_en (st_en),
      .store_fn (st_fn),
      .rx_byte  (rx_ts16),
      .rd_chan  (rd_chan),
      .rd_code  (rd_code)
   );
endmodule

// File: rtl/cas_mf_mux_chk.sv
module cas_mf_mux_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ccs_mode,
   input logic       frame_tick,
   input logic       tx_mf_align_n,
   input logic       tx_remote_alarm,
   input logic [7:0] tx_ccs_byte,
   input logic       wr_en,
   input logic [4:0] wr_chan,
   input logic [3:0] wr_code,
   input logic [7:0] tx_ts16,
   input logic [3:0] tx_frame_num,
   input logic [7:0] rx_ts16,
   input logic       rx_mf_lock,
   input logic       rx_mf_pulse,
   input logic [4:0] rd_chan,
   input logic [3:0] rd_code
);
   // R10
   pulse_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_mf_pulse |-> rx_mf_lock);

   // R10
   pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_mf_pulse |=> !rx_mf_pulse);

   // R5
   ccs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && ccs_mode) |=> (tx_ts16 == $past(tx_ccs_byte)));

   // R5
   ccs_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ccs_mode |=> !rx_mf_lock);

   // R1
   forced_frame0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && !ccs_mode && !tx_mf_align_n) |=>
         (tx_frame_num == 4'd0 && tx_ts16[7:4] == 4'b0000));

   // R6
   hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> $stable(tx_ts16) && $stable(tx_frame_num));

   // R8
   lock_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_tick && !ccs_mode) |=> $stable(rx_mf_lock));

   // R7
   lock_rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_mf_lock) |-> rx_mf_pulse);
endmodule

bind cas_mf_mux cas_mf_mux_chk i_chk (.*);

// File: tb/test_cas_mf_mux.sv
module test_cas_mf_mux;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ccs_mode = 1'b0;
   logic       frame_tick = 1'b0;
   logic       tx_mf_align_n = 1'b1;
   logic       tx_remote_alarm = 1'b0;
   logic [7:0] tx_ccs_byte = 8'h00;
   logic       wr_en = 1'b0;
   logic [4:0] wr_chan = 5'd0;
   logic [3:0] wr_code = 4'd0;
   logic [7:0] tx_ts16;
   logic [3:0] tx_frame_num;
   logic [7:0] rx_ts16 = 8'hFF;
   logic       rx_mf_lock;
   logic       rx_mf_pulse;
   logic [4:0] rd_chan = 5'd0;
   logic [3:0] rd_code;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   logic [3:0] tx_code   [1:30];
   logic [3:0] rx_send   [1:30];
   logic [3:0] rx_expect [1:30];
   int tfn = 15;

   always #10 clk = ~clk;

   cas_mf_mux i_cas_mf_mux (.*);

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] tx_model(input int fn, input logic alarm);
      if (fn == 0) return {4'b0000, 1'b1, alarm, 1'b1, 1'b1};
      return {tx_code[fn], tx_code[fn + 15]};
   endfunction

   function automatic logic [7:0] mf_byte(input int fn);
      if (fn == 0) return 8'h0B;
      return {rx_send[fn], rx_send[fn + 15]};
   endfunction

   task automatic do_write(input int ch, input logic [3:0] code);
      @(negedge clk);
      wr_en = 1'b1; wr_chan = 5'(ch); wr_code = code;
      @(negedge clk);
      wr_en = 1'b0;
      if (ch >= 1 && ch <= 30) tx_code[ch] = code;
   endtask

   // one frame: tick, then compare tx byte, lock and pulse
   task automatic tick(input logic align_n, input logic [7:0] rxb,
                       input logic exp_lock, input logic exp_pulse, input string rtag);
      logic [7:0] exp_tx;
      logic       alarm;
      @(negedge clk);
      frame_tick = 1'b1;
      tx_mf_align_n = align_n;
      rx_ts16 = rxb;
      tx_ccs_byte = 8'($urandom);
      alarm = tx_remote_alarm;
      tfn = align_n ? (tfn + 1) % 16 : 0;
      exp_tx = ccs_mode ? tx_ccs_byte : tx_model(tfn, alarm);
      @(negedge clk);
      frame_tick = 1'b0;
      tx_mf_align_n = 1'b1;
      if (ccs_mode) check("R5 tx passthrough", tx_ts16, exp_tx);
      else if (tfn == 0) check("R2 frame0 byte", tx_ts16, exp_tx);
      else check("R3 signalling byte", tx_ts16, exp_tx);
      check("R1 frame number", {4'd0, tx_frame_num}, 8'(tfn));
      check({rtag, " lock"}, {7'd0, rx_mf_lock}, {7'd0, exp_lock});
      check("R10 pulse", {7'd0, rx_mf_pulse}, {7'd0, exp_pulse});
      @(negedge clk);
      check("R6 hold", tx_ts16, exp_tx);
   endtask

   task automatic read_all(input string req);
      for (int c = 1; c <= 30; c++) begin
         @(negedge clk);
         rd_chan = 5'(c);
         #1;
         check(req, {4'd0, rd_code}, {4'd0, rx_expect[c]});
      end
   endtask

   task automatic send_mf(input logic bad0, input logic exp_lock0, input logic exp_pulse0,
                          input logic lock_rest, input string rtag);
      tick(1'b1, bad0 ? 8'h5B : mf_byte(0), exp_lock0, exp_pulse0, rtag);
      for (int f = 1; f <= 15; f++) tick(1'b1, mf_byte(f), lock_rest, 1'b0, rtag);
   endtask

   task automatic new_rx_codes;
      for (int c = 1; c <= 30; c++)
         rx_send[c] = (c <= 15) ? 4'($urandom_range(1, 15)) : 4'($urandom_range(0, 15));
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int c = 1; c <= 30; c++) begin
         tx_code[c] = 4'b1101;
         rx_expect[c] = 4'b1111;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 reset state
      check("R6 reset tx byte", tx_ts16, 8'hFF);
      check("R7 reset lock", {7'd0, rx_mf_lock}, 8'd0);
      check("R10 reset pulse", {7'd0, rx_mf_pulse}, 8'd0);
      read_all("R9 reset codes");
      rd_chan = 5'd0; #1; check("R11 channel 0", {4'd0, rd_code}, 8'd0);
      rd_chan = 5'd31; #1; check("R11 channel 31", {4'd0, rd_code}, 8'd0);

      // R4: idle codes until written
      for (int f = 0; f < 16; f++) tick(1'b1, 8'hFF, 1'b0, 1'b0, "R7");
      for (int c = 1; c <= 30; c++) do_write(c, 4'($urandom_range(0, 15)));
      do_write(0, 4'h0);
      do_write(31, 4'h0);
      do_write(7, 4'h0);
      do_write(22, 4'hF);
      // R4 ignored channel writes show as unchanged tx bytes below
      for (int f = 0; f < 21; f++) begin
         tx_remote_alarm = f[0];
         tick(1'b1, 8'hFF, 1'b0, 1'b0, "R7");
      end
      // R1 forced alignment in mid multiframe
      tick(1'b0, 8'hFF, 1'b0, 1'b0, "R7");
      for (int f = 0; f < 18; f++) tick(1'b1, 8'hFF, 1'b0, 1'b0, "R7");

      // receive: garbage then hunt, confirm, lock
      new_rx_codes();
      repeat (3) tick(1'b1, 8'hA5, 1'b0, 1'b0, "R7");
      send_mf(1'b0, 1'b0, 1'b0, 1'b0, "R7 confirm");
      read_all("R9 no store while unlocked");
      send_mf(1'b0, 1'b1, 1'b1, 1'b1, "R7 lock");
      for (int c = 1; c <= 30; c++) rx_expect[c] = rx_send[c];
      read_all("R9 stored codes");

      // R8 single miss keeps lock, codes still stored
      new_rx_codes();
      send_mf(1'b1, 1'b1, 1'b1, 1'b1, "R8 single miss");
      for (int c = 1; c <= 30; c++) rx_expect[c] = rx_send[c];
      read_all("R9 stored after miss");

      // R8 second miss drops lock; following codes not stored
      new_rx_codes();
      send_mf(1'b1, 1'b0, 1'b0, 1'b0, "R8 drop");
      read_all("R9 frozen after drop");

      // relock (R7) then common-channel mode (R5)
      new_rx_codes();
      send_mf(1'b0, 1'b0, 1'b0, 1'b0, "R7 reconfirm");
      send_mf(1'b0, 1'b1, 1'b1, 1'b1, "R7 relock");
      for (int c = 1; c <= 30; c++) rx_expect[c] = rx_send[c];
      @(negedge clk);
      ccs_mode = 1'b1;
      new_rx_codes();
      send_mf(1'b0, 1'b0, 1'b0, 1'b0, "R5 ccs unlock");
      read_all("R5 no store in ccs");
      ccs_mode = 1'b0;
      tick(1'b0, 8'hFF, 1'b0, 1'b0, "R5 ccs exit");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule